// File: doc/BRIEF.md
# Pulse Width Measurement Timer

This block measures the time between successive qualifying transitions on an external signal. An up-counter of `CNT_W` bits (16 by default) advances on each cycle where a count-clock enable is high. When a selected transition is seen on the synchronized input, three things happen together: the running count is copied into a capture register, the counter returns to zero, and a one-cycle capture interrupt pulse is issued. Software then reads the captured count to work out the interval.

If no qualifying transition arrives before the counter passes its all-ones value, the counter wraps to zero on the next enabled cycle and keeps running. On that wrap the block issues a one-cycle overflow interrupt pulse and sets a sticky overflow flag, which stays set until a clear strobe is applied. A measured interval is `capture + 1` enabled cycles with no wrap in between. With one wrap it is `capture + 2^CNT_W + 1` enabled cycles.

A run enable gates the whole measurement. While it is low, the counter is held at zero, and no capture or overflow can occur.

Top module: `pulse_width_timer`

## Requirements
- R1: While `run_i` is low, the counter is held at zero. After `run_i` rises, each enabled cycle adds one. A first qualifying transition that is detected on the k-th enabled cycle after `run_i` rises (k counted from 1) captures the value k-1.
- R2: On a detected transition, the present count goes into `cap_val_o` and the counter goes to zero in the same clock edge. With the enable always high and qualifying transitions N enabled cycles apart, every capture after the first equals N-1 when N is at most 2^CNT_W.
- R3: Each detected transition gives exactly one `cap_irq_o` pulse. The pulse is high for the single cycle that follows the clock edge at which `cap_val_o` takes its new value.
- R4: On a cycle with `cnt_en_i` low, nothing changes: the counter, the capture and the interrupts stay as they are, and no transition is detected. With the enable high one cycle in D, and transitions N enabled cycles apart, the captures equal N-1.
- R5: When the counter is at all-ones and no transition is detected on an enabled cycle, the counter goes to zero and `ovf_irq_o` pulses for one cycle. Counting then continues, so transitions 2^CNT_W+M enabled cycles apart capture M-1 and give one overflow pulse per interval.
- R6: `ovf_flag_o` is set by every overflow. It stays set until an `ovf_clr_i` strobe is sampled. If a clear strobe and an overflow fall on the same edge, the flag is set.
- R7: `edge_sel_i` selects the qualifying transition. The encoding is 2'b00 none, 2'b01 low-to-high, 2'b10 high-to-low and 2'b11 either. With 2'b00 there are no captures and the counter only wraps.
- R8: `cap_in_i` passes through two synchronizing flip-flops. A change applied just after a clock edge is detected at the third enabled edge that follows.
- R9: Dropping `run_i` leaves `cap_val_o` and `ovf_flag_o` untouched, and no interrupt occurs while it is low, whatever `cap_in_i` does.
- R10: A transition detected on the same enabled cycle as an all-ones count is a capture of the all-ones value. It is not an overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run_i | input | 1 | Run enable; low holds the counter at zero |
| cnt_en_i | input | 1 | Count-clock enable |
| cap_in_i | input | 1 | External capture input, asynchronous |
| edge_sel_i | input | 2 | Qualifying transition select (see R7) |
| ovf_clr_i | input | 1 | Clear strobe for the overflow flag |
| cap_val_o | output | CNT_W | Captured count |
| cap_irq_o | output | 1 | Capture interrupt pulse |
| ovf_irq_o | output | 1 | Overflow interrupt pulse |
| ovf_flag_o | output | 1 | Sticky overflow flag |

## Verification
A counter that is off by one, or that fails to return to zero at a capture, shows up in the very next captured value. The interval sweeps compare every capture against N-1, so such an error appears at the second pulse of a sweep. A wrong transition qualifier or a wrong synchronizer depth changes the number of captures, or moves the first capture after run start away from the value 2. A wrap fault, such as a missed overflow, a lost sticky flag, or a clear that wins over a simultaneous overflow, shows up within one counter period as a wrong pulse count or a wrong flag level.

// File: rtl/pwt_pkg.sv
package pwt_pkg;
  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/pwt_rst_sync.sv
module pwt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/pwt_edge_detect.sv
module pwt_edge_detect
  import pwt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sig_i,
  input  logic       sample_en_i,
  input  logic [1:0] sel_i,
  output logic       edge_o
);
  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic                   prev_q, prev_d;
  logic                   synced, rise, fall, hit;
  edge_sel_e              mode;

  assign synced = sync_q[SYNC_STAGES-1];
  assign mode   = edge_sel_e'(sel_i);

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], sig_i};
    prev_d = prev_q;
    if (sample_en_i) prev_d = synced;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  always_comb begin
    rise = synced & ~prev_q;
    fall = ~synced & prev_q;
    unique case (mode)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
    edge_o = sample_en_i & hit;
  end

  // R7: the none selection never qualifies a transition
  a_r7_none_selected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i == EDGE_NONE) |-> !edge_o);
  // R4: a disabled cycle detects nothing
  a_r4_no_edge_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sample_en_i |-> !edge_o);
endmodule

// File: rtl/pwt_counter.sv
module pwt_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic             edge_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_irq_o,
  output logic             ovf_irq_o,
  output logic             ovf_flag_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] cap_q, cap_d;
  logic             cap_irq_q, cap_irq_d;
  logic             ovf_irq_q, ovf_irq_d;
  logic             flag_q, flag_d;
  logic             step;

  assign step = run_i & cnt_en_i;

  always_comb begin
    cnt_d     = cnt_q;
    cap_d     = cap_q;
    cap_irq_d = 1'b0;
    ovf_irq_d = 1'b0;
    flag_d    = flag_q & ~ovf_clr_i;
    if (!run_i) begin
      cnt_d = '0;
    end else if (step) begin
      if (edge_i) begin
        cap_d     = cnt_q;
        cnt_d     = '0;
        cap_irq_d = 1'b1;
      end else if (cnt_q == CNT_MAX) begin
        cnt_d     = '0;
        ovf_irq_d = 1'b1;
        flag_d    = 1'b1;
      end else begin
        cnt_d = cnt_q + CNT_ONE;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      cap_q     <= '0;
      cap_irq_q <= 1'b0;
      ovf_irq_q <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      cap_q     <= cap_d;
      cap_irq_q <= cap_irq_d;
      ovf_irq_q <= ovf_irq_d;
      flag_q    <= flag_d;
    end
  end

  assign cap_val_o  = cap_q;
  assign cap_irq_o  = cap_irq_q;
  assign ovf_irq_o  = ovf_irq_q;
  assign ovf_flag_o = flag_q;

  // R2: the counter sits at zero when a capture pulse is out
  a_r2_zero_after_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_irq_q |-> (cnt_q == '0));
  // R9: run low clears the count and keeps capture and flag
  a_r9_run_low_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0) && $stable(cap_q) && !cap_irq_q && !ovf_irq_q);
  // R4: a disabled cycle changes nothing
  a_r4_hold_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !cnt_en_i) |=> $stable(cnt_q) && $stable(cap_q) && !cap_irq_q && !ovf_irq_q);
  // R5: the overflow pulse lasts one cycle
  a_r5_single_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_q |=> !ovf_irq_q);
  // R6: the flag is set alongside every overflow
  a_r6_flag_with_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_irq_q |-> flag_q);
  // R6: the flag stays set until a clear is sampled
  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !ovf_clr_i) |=> flag_q);
  // R10: capture and overflow never occur on the same edge
  a_r10_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_irq_q && ovf_irq_q));
endmodule

// File: rtl/pulse_width_timer.sv
module pulse_width_timer #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  parameter int RST_STAGES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             cnt_en_i,
  input  logic             cap_in_i,
  input  logic [1:0]       edge_sel_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] cap_val_o,
  output logic             cap_irq_o,
  output logic             ovf_irq_o,
  output logic             ovf_flag_o
);
  logic rst_n_int;
  logic edge_hit;

  pwt_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk_i   (clk_i),
    .arst_ni (rst_ni),
    .rst_no  (rst_n_int)
  );

  pwt_edge_detect #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_int),
    .sig_i       (cap_in_i),
    .sample_en_i (cnt_en_i),
    .sel_i       (edge_sel_i),
    .edge_o      (edge_hit)
  );

  pwt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .run_i      (run_i),
    .cnt_en_i   (cnt_en_i),
    .edge_i     (edge_hit),
    .ovf_clr_i  (ovf_clr_i),
    .cap_val_o  (cap_val_o),
    .cap_irq_o  (cap_irq_o),
    .ovf_irq_o  (ovf_irq_o),
    .ovf_flag_o (ovf_flag_o)
  );
endmodule

// File: tb/sim_pulse_width_timer.sv
module sim_pulse_width_timer;
  localparam int W    = 10;
  localparam int FULL = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         run = 1'b0;
  logic         en = 1'b0;
  logic         cap_in = 1'b0;
  logic         clr = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic [W-1:0] cap_val;
  logic         cap_irq, ovf_irq, ovf_flag;

  int nchk = 0;
  int nerr = 0;
  int div = 1;
  int cyc = 0;
  int ncap = 0;
  int novf = 0;
  int novf_btw = 0;
  int caplog [0:63];

  always #2 clk = ~clk;

  pulse_width_timer #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .cnt_en_i(en),
    .cap_in_i(cap_in), .edge_sel_i(sel), .ovf_clr_i(clr),
    .cap_val_o(cap_val), .cap_irq_o(cap_irq), .ovf_irq_o(ovf_irq),
    .ovf_flag_o(ovf_flag)
  );

  // enable pattern: high one cycle in div
  always @(negedge clk) begin
    en  <= ((cyc % div) == 0);
    cyc <= cyc + 1;
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (cap_irq) begin
        if (ncap < 64) caplog[ncap] = int'(cap_val);
        ncap++;
      end
      if (ovf_irq) begin
        novf++;
        if (ncap > 0) novf_btw++;
      end
    end
  end

  task automatic chk(string req, longint act, longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
    #1;
  endtask

  task automatic clear_logs();
    ncap = 0; novf = 0; novf_btw = 0;
  endtask

  task automatic restart(logic [1:0] s, int d);
    run = 1'b0; cap_in = 1'b0; sel = s; div = d;
    step(4 * d + 6);
    clear_logs();
    run = 1'b1;
    step(3);
  endtask

  task automatic interval_phase(string req, logic [1:0] s, int d, int n, int t);
    int np, c, expv;
    restart(s, d);
    for (int k = 0; k < t; k++) begin
      step(n * d);
      cap_in = ~cap_in;
    end
    step(3 * d + 6);
    np   = (s == 2'b11) ? n : 2 * n;
    c    = (s == 2'b11) ? t : t / 2;
    expv = (np - 1) % FULL;
    chk(req, ncap, c);
    for (int k = 1; k < c; k++) chk(req, caplog[k], expv);
    chk({req, " overflows"}, novf_btw, (c - 1) * ((np - 1) / FULL));
  endtask

  initial begin
    #(4 * 190000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    int cap_keep;
    logic flag_keep;
    step(3);
    rst_n = 1'b1;
    step(4);
    // reset state
    chk("R1 reset cap", cap_val, 0);
    chk("R3 reset cap_irq", cap_irq, 0);
    chk("R5 reset ovf_irq", ovf_irq, 0);
    chk("R6 reset flag", ovf_flag, 0);

    // R1 / R8: first capture after run start
    run = 1'b0; cap_in = 1'b0; sel = 2'b11; div = 1;
    step(8);
    clear_logs();
    run = 1'b1; cap_in = 1'b1;
    step(8);
    chk("R1 captures", ncap, 1);
    chk("R8 first capture", caplog[0], 2);

    // R2 R3 R4 R7 sweeps
    for (int s = 1; s <= 3; s++)
      for (int d = 1; d <= 3; d++) begin
        interval_phase("R2 R4 R7 sweep n1", 2'(s), d, 1, 6);
        interval_phase("R2 R4 R7 sweep n2", 2'(s), d, 2, 6);
        interval_phase("R3 sweep n3", 2'(s), d, 3, 6);
        interval_phase("R2 sweep n5", 2'(s), d, 5, 6);
        interval_phase("R4 sweep n17", 2'(s), d, 17, 6);
      end

    // boundaries around wrap
    interval_phase("R2 n=FULL-1", 2'b11, 1, FULL - 1, 4);
    interval_phase("R10 n=FULL", 2'b11, 1, FULL, 4);
    interval_phase("R5 n=FULL+1", 2'b11, 1, FULL + 1, 4);
    interval_phase("R5 n=2FULL+3", 2'b11, 1, 2 * FULL + 3, 4);

    // R9: run low keeps capture and flag, no interrupts
    cap_keep = int'(cap_val);
    flag_keep = ovf_flag;
    run = 1'b0;
    step(4);
    clear_logs();
    for (int k = 0; k < 6; k++) begin
      step(3);
      cap_in = ~cap_in;
    end
    step(FULL + 20);
    chk("R9 no capture", ncap, 0);
    chk("R9 no overflow", novf, 0);
    chk("R9 capture kept", cap_val, cap_keep);
    chk("R9 flag kept", ovf_flag, flag_keep);

    // R7: none selected, counter just wraps
    restart(2'b00, 1);
    for (int k = 0; k < 21; k++) begin
      step(100);
      cap_in = ~cap_in;
    end
    chk("R7 none no capture", ncap, 0);
    chk("R7 none overflows", novf, 2);
    chk("R6 flag set", ovf_flag, 1);

    // R6: clear strobe alone
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk("R6 clear", ovf_flag, 0);
    step(5);
    chk("R6 stays clear", ovf_flag, 0);

    // R5 / R6: exact wrap timing and clear colliding with overflow
    run = 1'b0; sel = 2'b00; div = 1;
    step(6);
    run = 1'b1;
    for (int k = 0; k < FULL; k++) @(posedge clk);
    step(1);
    chk("R5 wrap pulse", ovf_irq, 1);
    chk("R6 flag on wrap", ovf_flag, 1);
    step(1);
    chk("R5 pulse one cycle", ovf_irq, 0);
    for (int k = 0; k < FULL - 2; k++) @(posedge clk);
    step(1);
    clr = 1'b1;
    step(1);
    chk("R5 second wrap", ovf_irq, 1);
    chk("R6 overflow wins clear", ovf_flag, 1);
    clr = 1'b0;
    step(3);
    chk("R6 still set", ovf_flag, 1);
    clr = 1'b1;
    step(1);
    clr = 1'b0;
    chk("R6 cleared again", ovf_flag, 0);

    $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule